// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block sequences an external dual-slope integrating front end. After a start request it walks three phases in a fixed order. First the integrator is held at zero for a programmed number of cycles. Then the unknown input is applied for a fixed, programmed number of cycles. Then a reference of opposite sign is applied while a counter runs. The count stops at the first change of the comparator output, which marks the integrator's return to zero. That final count is proportional to the input magnitude, and it is reported with the input sign and a one-cycle done strobe.

The integration length is normally set to a whole number of mains periods (50 Hz or 60 Hz) so that line pickup averages out. The comparator is asynchronous to the block's clock, so it passes through a two-stage synchronizer before use. If the comparator never flips, a programmable maximum count ends the measurement and flags overrange.

States: `ST_IDLE`, `ST_ZERO`, `ST_INTEG`, `ST_DEINT`. Transitions:
- IDLE→ZERO on start.
- ZERO→INTEG when the zeroing count is reached.
- INTEG→DEINT when the window ends, latching the polarity.
- DEINT→IDLE on a comparator edge (valid result) or on timeout (overrange).

Top module: `dslope_seq`

## Requirements
- R1: During and after reset the block is idle: busy_o, done_o, ovr_o, sign_o, all three select outputs and result_o are 0.
- R2: A start_i pulse in idle enters zeroing on the next clock; sel_zero_o stays high for max(zero_len_i,1) cycles.
- R3: Integration follows zeroing directly; sel_input_o stays high for max(int_len_i,1) cycles.
- R4: sel_ref_o rises in the cycle right after the last sel_input_o cycle, with no idle cycle between.
- R5: The synchronized comparator level at the last integration cycle is latched as polarity (1 = positive input). During de-integration ref_neg_o equals that level and does not change. sign_o is reported as its inverse (1 = negative input).
- R6: The de-integration count starts at 0 in the first sel_ref_o cycle. If cmp_i changes in de-integration cycle N, the two-stage synchronizer delays the edge so that result_o = N+2, ovr_o = 0, and sel_ref_o lasts N+3 cycles.
- R7: If no comparator edge is seen before the count reaches max_len_i-1, de-integration ends after max_len_i cycles with ovr_o = 1 and result_o = max_len_i. An edge in that last cycle still gives a valid result.
- R8: done_o is high for exactly one cycle, in the first cycle in which result_o, sign_o and ovr_o hold the new values. The block is idle in that same cycle.
- R9: start_i while busy is ignored: it neither restarts nor queues a conversion.
- R10: busy_o is high in every cycle from the first zeroing cycle through the last de-integration cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only in idle |
| cmp_i | input | 1 | Zero-crossing comparator, 1 = integrator above zero, asynchronous |
| zero_len_i | input | CNT_W | Zeroing phase length in cycles |
| int_len_i | input | CNT_W | Fixed integration window in cycles |
| max_len_i | input | CNT_W | De-integration timeout in cycles |
| sel_zero_o | output | 1 | Integrator zeroing switch |
| sel_input_o | output | 1 | Input-to-integrator switch |
| sel_ref_o | output | 1 | Reference-to-integrator switch |
| ref_neg_o | output | 1 | 1 = negative reference selected during de-integration |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | CNT_W | De-integration count |
| sign_o | output | 1 | 1 = negative input |
| ovr_o | output | 1 | Result is an overrange timeout |

## Verification
A wrong phase counter shows up directly in the width of the sel_zero_o, sel_input_o or sel_ref_o windows, within the same conversion. A wrong next-state choice shows as a gap or an overlap between windows, or as a conversion restarted by a late start request. A faulty polarity latch or synchronizer shows at the end of the same conversion, as a wrong ref_neg_o level or a result_o that is off by the two-cycle synchronizer delay. Timeout and edge-priority faults are exposed by runs whose comparator flips on, or never before, the last allowed count.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ZERO  = 2'd1,
        ST_INTEG = 2'd2,
        ST_DEINT = 2'd3
    } phase_e;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
    import dslope_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_s_i,
    input  logic [CNT_W-1:0] zero_len_i,
    input  logic [CNT_W-1:0] int_len_i,
    input  logic [CNT_W-1:0] max_len_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pol_o,
    output logic             load_o,
    output logic             ovr_hit_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W:0]   EXT_ONE = {{CNT_W{1'b0}}, 1'b1};

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pol_q, pol_d;
    logic             cmp_q;
    logic             flip;

    // last cycle of a phase of length lim (a length of 0 behaves as 1)
    function automatic logic at_end(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] lim);
        return ({1'b0, c} + EXT_ONE) >= {1'b0, lim};
    endfunction

    assign flip = cmp_s_i ^ cmp_q;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        pol_d     = pol_q;
        load_o    = 1'b0;
        ovr_hit_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ZERO;
                    cnt_d   = '0;
                end
            end
            ST_ZERO: begin
                if (at_end(cnt_q, zero_len_i)) begin
                    state_d = ST_INTEG;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_INTEG: begin
                if (at_end(cnt_q, int_len_i)) begin
                    state_d = ST_DEINT;
                    cnt_d   = '0;
                    pol_d   = cmp_s_i;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_DEINT: begin
                if (flip) begin
                    load_o  = 1'b1;
                    state_d = ST_IDLE;
                end else if (at_end(cnt_q, max_len_i)) begin
                    load_o    = 1'b1;
                    ovr_hit_o = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pol_q   <= 1'b0;
            cmp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pol_q   <= pol_d;
            cmp_q   <= cmp_s_i;
        end
    end

    assign phase_o = state_q;
    assign cnt_o   = cnt_q;
    assign pol_o   = pol_q;

    AST_DEINT_AFTER_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_INTEG && $past(state_q) == ST_INTEG) |-> state_q == ST_DEINT); // R4
    AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEINT && $past(state_q) == ST_DEINT) |-> $stable(pol_q)); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEINT && start_i) |=> state_q != ST_ZERO); // R9
    AST_DEINT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEINT && max_len_i != '0) |-> cnt_q < max_len_i); // R7
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             ovr_i,
    input  logic             pol_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] max_i,
    output logic [CNT_W-1:0] result_o,
    output logic             sign_o,
    output logic             ovr_o,
    output logic             done_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            sign_o   <= 1'b0;
            ovr_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= load_i;
            if (load_i) begin
                result_o <= ovr_i ? max_i : cnt_i;
                sign_o   <= ~pol_i;
                ovr_o    <= ovr_i;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic [CNT_W-1:0] zero_len_i,
    input  logic [CNT_W-1:0] int_len_i,
    input  logic [CNT_W-1:0] max_len_i,
    output logic             sel_zero_o,
    output logic             sel_input_o,
    output logic             sel_ref_o,
    output logic             ref_neg_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] result_o,
    output logic             sign_o,
    output logic             ovr_o
);
    logic             cmp_s;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             pol, load, ovr_hit;

    dslope_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
    );

    dslope_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_s_i(cmp_s),
        .zero_len_i(zero_len_i), .int_len_i(int_len_i), .max_len_i(max_len_i),
        .phase_o(phase), .cnt_o(cnt), .pol_o(pol), .load_o(load), .ovr_hit_o(ovr_hit)
    );

    dslope_result #(.CNT_W(CNT_W)) u_res (
        .clk(clk), .rst_n(rst_n), .load_i(load), .ovr_i(ovr_hit), .pol_i(pol),
        .cnt_i(cnt), .max_i(max_len_i),
        .result_o(result_o), .sign_o(sign_o), .ovr_o(ovr_o), .done_o(done_o)
    );

    always_comb begin
        sel_zero_o  = (phase == ST_ZERO);
        sel_input_o = (phase == ST_INTEG);
        sel_ref_o   = (phase == ST_DEINT);
        ref_neg_o   = (phase == ST_DEINT) && pol;
        busy_o      = (phase != ST_IDLE);
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_ZERO_BEFORE_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_input_o) |-> $past(sel_zero_o)); // R3
endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             cmp_i = 1'b0;
    logic [CNT_W-1:0] zero_len_i = '0;
    logic [CNT_W-1:0] int_len_i = '0;
    logic [CNT_W-1:0] max_len_i = '0;
    logic             sel_zero_o, sel_input_o, sel_ref_o, ref_neg_o;
    logic             busy_o, done_o, sign_o, ovr_o;
    logic [CNT_W-1:0] result_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dslope_seq #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .zero_len_i(zero_len_i), .int_len_i(int_len_i), .max_len_i(max_len_i),
        .sel_zero_o(sel_zero_o), .sel_input_o(sel_input_o), .sel_ref_o(sel_ref_o),
        .ref_neg_o(ref_neg_o), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .sign_o(sign_o), .ovr_o(ovr_o)
    );

    // polarity, zero length, integration length, flip cycle (-1 = none), timeout
    localparam int NVEC = 6;
    localparam int VEC [NVEC][5] = '{
        '{1, 3,  8,  5, 40},
        '{0, 2, 10,  0, 40},
        '{1, 1,  1, 12, 40},
        '{0, 0,  5, -1, 20},
        '{1, 4,  6, 17, 20},
        '{0, 5, 12, 30, 25}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic run_conv(input int pol, input int zl, input int il,
                            input int nflip, input int ml, input bit poke);
        int  zc = 0, ic = 0, rc = 0, j = -1, gap = 0, refbad = 0, busylow = 0, guard = 0;
        bit  prev_in = 1'b0, seen = 1'b0;
        int  exp_res, exp_ovr, exp_rc;
        if (nflip >= 0 && nflip + 2 < ml) begin
            exp_res = nflip + 2; exp_ovr = 0; exp_rc = nflip + 3;
        end else begin
            exp_res = ml; exp_ovr = 1; exp_rc = ml;
        end
        cmp_i      = pol[0];
        zero_len_i = CNT_W'(zl);
        int_len_i  = CNT_W'(il);
        max_len_i  = CNT_W'(ml);
        repeat (4) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        while (!seen && guard < 5000) begin
            guard++;
            start_i = 1'b0;
            if (!busy_o && !done_o) busylow++;
            if (sel_zero_o) zc++;
            if (sel_input_o) ic++;
            if (sel_ref_o) begin
                rc++; j++;
                if (rc == 1 && !prev_in) gap++;
                if (ref_neg_o != pol[0]) refbad++;
                if (nflip >= 0 && j == nflip) cmp_i = ~pol[0];
                if (poke && j == 1) start_i = 1'b1;
            end
            prev_in = sel_input_o;
            if (done_o) seen = 1'b1;
            else @(negedge clk);
        end
        start_i = 1'b0;
        chk("R8 done seen", int'(seen), 1);
        chk("R2 zeroing cycles", zc, at_least_one(zl));
        chk("R3 integration cycles", ic, at_least_one(il));
        chk("R4 gap before de-integration", gap, 0);
        chk("R5 reference polarity", refbad, 0);
        chk("R5 sign", int'(sign_o), 1 - pol);
        chk("R6 R7 result", int'(result_o), exp_res);
        chk("R7 overrange flag", int'(ovr_o), exp_ovr);
        chk("R6 R7 de-integration cycles", rc, exp_rc);
        chk("R10 busy during conversion", busylow, 0);
        chk("R8 idle at done", int'(busy_o), 0);
        @(negedge clk);
        chk("R8 done width", int'(done_o), 0);
        if (poke) begin
            repeat (5) @(negedge clk);
            chk("R9 no restart busy", int'(busy_o), 0);
            chk("R9 no restart zero", int'(sel_zero_o), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy in reset", int'(busy_o), 0);
        chk("R1 selects in reset", int'({sel_zero_o, sel_input_o, sel_ref_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 result after reset", int'(result_o), 0);
        chk("R1 flags after reset", int'({ovr_o, sign_o}), 0);

        for (int v = 0; v < NVEC; v++)
            run_conv(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0);

        // R9 start request during de-integration
        run_conv(1, 2, 4, 10, 40, 1'b1);

        // R1 reset in the middle of integration
        cmp_i = 1'b1; zero_len_i = 16'd2; int_len_i = 16'd20; max_len_i = 16'd40;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R3 integrating before reset", int'(sel_input_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy after mid reset", int'(busy_o), 0);
        chk("R1 selects after mid reset", int'({sel_zero_o, sel_input_o, sel_ref_o}), 0);
        chk("R1 result after mid reset", int'(result_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 stays idle", int'(busy_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule